// File: doc/BRIEF.md
# Reference-Selecting Digital Clock Loop Controller

This block is the digital heart of a network-element clock loop. Three candidate timing references arrive as single-cycle edge strobes: one recovered from the line side, one from a tributary port and one from a dedicated external timing input. A divided-down feedback strobe comes back from an external oscillator. The block checks the health of each reference and picks the preferred usable one. It counts the phase difference between that reference and the feedback and runs a proportional-integral filter. The result is a 16-bit control word for the DAC that steers the oscillator.

While it tracks a reference, the block keeps a smoothed copy of the filter's frequency word. If every usable reference disappears, it replays that copy in holdover. If no history exists yet, it drives a programmable nominal word (free-run). A change of reference, or a return from holdover, starts the phase count from zero. The integrator is loaded from the stored history so that the control word does not step.

Top module: `clk_steer_dpll`

## Requirements
- R1: After a synchronous active-low reset, `mode` is free-run (2'b00), `sel_idx` is 3 (none) and `ctrl_word` equals `ctrl_nom`.
- R2: An input becomes usable on its `requal_cnt`-th reference edge in a row with no loss in between (0 acts as 1). It is declared lost on the `loss_limit`-th feedback edge counted since its last reference edge, which clears its count of good edges.
- R3: Among inputs that are both enabled (`ref_en[i]`) and usable, the one whose 2-bit priority `ref_prio[2i+1:2i]` is lowest is selected, and a tie goes to the lower index. When one is selected, `mode` is locked (2'b01) and `sel_idx` gives its index. Otherwise `sel_idx` is 3.
- R4: The phase count rises by one for each edge of the selected reference and falls by one for each feedback edge. It restarts at zero whenever a reference is newly selected.
- R5: On each feedback edge while locked on the same input, with phase count p and integrator I, the integrator becomes I + 2p. The control word becomes `ctrl_nom` + I + 2p + 16p, where 2p and 16p come from the default shifts of 1 and 4.
- R6: The filtered control word is clamped to the range from `ctrl_min` to `ctrl_max`.
- R7: With no selectable input and no valid history, `mode` is free-run and `ctrl_word` follows `ctrl_nom`.
- R8: The history word is updated only on feedback edges while locked with |p| not above `lock_win`. Each update moves it toward the new control word by one eighth of the gap, and by at least one. It becomes valid after 32 such updates.
- R9: With no selectable input and valid history, `mode` is holdover (2'b10) and `ctrl_word` holds the history word steady.
- R10: When a reference is newly selected, the control word takes the history word (or `ctrl_nom` if there is no history). The integrator is loaded to match, so the first filter update with zero phase error gives the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_edge | input | 3 | Edge strobes of the three references (0 line, 1 tributary, 2 external) |
| ref_en | input | 3 | Per-input enable for selection |
| ref_prio | input | 6 | 2-bit priority per input, lower wins |
| fb_edge | input | 1 | Edge strobe of the divided oscillator feedback |
| loss_limit | input | 8 | Feedback edges without a reference edge that declare loss (at least 1) |
| requal_cnt | input | 4 | Consecutive reference edges needed to qualify |
| lock_win | input | 12 | Phase window for history updates |
| ctrl_nom | input | 16 | Nominal control word |
| ctrl_min | input | 16 | Lower clamp of the control word |
| ctrl_max | input | 16 | Upper clamp of the control word |
| ctrl_word | output | 16 | Control word for the oscillator DAC |
| mode | output | 2 | 00 free-run, 01 locked, 10 holdover |
| sel_idx | output | 2 | Selected input, 3 when none |

## Verification
The assertions check several rules on every cycle. The mode code stays legal, and the selected index agrees with the mode. The word stays within the clamp limits after each filter update. The word sits at the nominal value in free-run and stays frozen in holdover, and it does not step on the way from holdover back to lock. The bench scenarios cover what needs a history of stimulus. They sweep every priority and enable combination, time the qualification and loss of inputs, and step the phase through a range of values with the filter results computed arithmetically. They also confine history updates to the lock window and replay the converged word after every reference is cut.

// File: rtl/clk_steer_dpll.sv
module clk_steer_dpll #(
  parameter int NREF     = 3,
  parameter int CW       = 16,
  parameter int PW       = 12,
  parameter int IW       = 24,
  parameter int GW       = 8,
  parameter int QW       = 4,
  parameter int PSH      = 4,
  parameter int ISH      = 1,
  parameter int ASH      = 3,
  parameter int HOLD_MIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREF-1:0]   ref_edge,
  input  logic [NREF-1:0]   ref_en,
  input  logic [2*NREF-1:0] ref_prio,
  input  logic              fb_edge,
  input  logic [GW-1:0]     loss_limit,
  input  logic [QW-1:0]     requal_cnt,
  input  logic [PW-1:0]     lock_win,
  input  logic [CW-1:0]     ctrl_nom,
  input  logic [CW-1:0]     ctrl_min,
  input  logic [CW-1:0]     ctrl_max,
  output logic [CW-1:0]     ctrl_word,
  output logic [1:0]        mode,
  output logic [$clog2(NREF+1)-1:0] sel_idx
);
  localparam int SW  = $clog2(NREF + 1);
  localparam int LCW = $clog2(HOLD_MIN + 1);
  localparam logic [SW-1:0] NONE = SW'(NREF);
  localparam logic [1:0] M_FREE = 2'd0, M_LOCK = 2'd1, M_HOLD = 2'd2;

  logic [GW-1:0]          gap  [NREF];
  logic [QW-1:0]          good [NREF];
  logic [NREF-1:0]        qual;
  logic                   found, sw, track, sel_ref, hold_valid, in_win;
  logic [SW-1:0]          best;
  logic [1:0]             best_p;
  logic signed [PW-1:0]   phase, mag;
  logic signed [IW-1:0]   integ, integ_n, raw;
  logic [CW-1:0]          avg, word, avg_n;
  logic signed [CW:0]     diff, step;
  logic [LCW-1:0]         lock_cnt;
  logic [QW-1:0]          need;

  assign need = (requal_cnt == '0) ? QW'(1) : requal_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual <= '0;
      for (int i = 0; i < NREF; i++) begin
        gap[i]  <= '0;
        good[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREF; i++) begin
        if (ref_edge[i]) begin
          gap[i] <= '0;
          if (good[i] < need) good[i] <= good[i] + QW'(1);
          if ({1'b0, good[i]} + (QW+1)'(1) >= {1'b0, need}) qual[i] <= 1'b1;
        end else if (fb_edge) begin
          if ({1'b0, gap[i]} + (GW+1)'(1) >= {1'b0, loss_limit}) begin
            qual[i] <= 1'b0;
            good[i] <= '0;
          end else begin
            gap[i] <= gap[i] + GW'(1);
          end
        end
      end
    end
  end

  always_comb begin
    found   = 1'b0;
    best    = NONE;
    best_p  = '1;
    sel_ref = 1'b0;
    for (int i = 0; i < NREF; i++) begin
      if (ref_en[i] && qual[i] && (!found || ref_prio[2*i +: 2] < best_p)) begin
        found  = 1'b1;
        best   = SW'(i);
        best_p = ref_prio[2*i +: 2];
      end
      if (sel_idx == SW'(i)) sel_ref = ref_edge[i];
    end
  end

  assign sw    = found && (mode != M_LOCK || sel_idx != best);
  assign track = found && !sw;

  assign integ_n = integ + (IW'(phase) <<< ISH);
  assign raw     = $signed(IW'(ctrl_nom)) + integ_n + (IW'(phase) <<< PSH);
  assign word    = (raw < $signed(IW'(ctrl_min))) ? ctrl_min :
                   (raw > $signed(IW'(ctrl_max))) ? ctrl_max : raw[CW-1:0];
  assign mag     = (phase < 0) ? -phase : phase;
  assign in_win  = $unsigned(mag) <= lock_win;
  assign diff    = $signed({1'b0, word}) - $signed({1'b0, avg});
  assign step    = ((diff >>> ASH) == 0 && diff != 0) ? $signed((CW+1)'(1)) : (diff >>> ASH);
  assign avg_n   = avg + step[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= M_FREE;
      sel_idx    <= NONE;
      ctrl_word  <= ctrl_nom;
      phase      <= '0;
      integ      <= '0;
      avg        <= ctrl_nom;
      hold_valid <= 1'b0;
      lock_cnt   <= '0;
    end else begin
      mode    <= found ? M_LOCK : (hold_valid ? M_HOLD : M_FREE);
      sel_idx <= found ? best : NONE;
      if (sw) begin
        phase     <= '0;
        lock_cnt  <= '0;
        integ     <= hold_valid ? $signed(IW'(avg)) - $signed(IW'(ctrl_nom)) : '0;
        ctrl_word <= hold_valid ? avg : ctrl_nom;
      end else if (track) begin
        phase <= phase + PW'(sel_ref) - PW'(fb_edge);
        if (fb_edge) begin
          integ     <= integ_n;
          ctrl_word <= word;
          if (in_win) begin
            avg <= (!hold_valid && lock_cnt == '0) ? word : avg_n;
            if (lock_cnt < LCW'(HOLD_MIN)) lock_cnt <= lock_cnt + LCW'(1);
            if (lock_cnt >= LCW'(HOLD_MIN - 1)) hold_valid <= 1'b1;
          end
        end
      end else begin
        phase     <= '0;
        lock_cnt  <= '0;
        ctrl_word <= hold_valid ? avg : ctrl_nom;
      end
    end
  end
endmodule

// File: rtl/clk_steer_dpll_chk.sv
module clk_steer_dpll_chk #(
  parameter int NREF = 3,
  parameter int CW   = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [CW-1:0]             ctrl_nom,
  input logic [CW-1:0]             ctrl_min,
  input logic [CW-1:0]             ctrl_max,
  input logic [CW-1:0]             ctrl_word,
  input logic [1:0]                mode,
  input logic [$clog2(NREF+1)-1:0] sel_idx,
  input logic                      fb_edge
);
  localparam int SW = $clog2(NREF + 1);
  localparam logic [SW-1:0] NONE = SW'(NREF);

  a_r3_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  a_r3_none_unless_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> (sel_idx == NONE));

  a_r3_index_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (sel_idx < NONE));

  a_r6_clamp_limits: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b01 && $past(sel_idx) == sel_idx && $past(fb_edge)
     && $past(ctrl_min) == ctrl_min && $past(ctrl_max) == ctrl_max && ctrl_min <= ctrl_max)
    |-> (ctrl_word >= ctrl_min && ctrl_word <= ctrl_max));

  a_r7_free_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (ctrl_word == $past(ctrl_nom)));

  a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) == 2'b10) |-> $stable(ctrl_word));

  a_r10_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b10) |-> (ctrl_word == $past(ctrl_word)));
endmodule

bind clk_steer_dpll clk_steer_dpll_chk #(.NREF(NREF), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_nom(ctrl_nom), .ctrl_min(ctrl_min),
  .ctrl_max(ctrl_max), .ctrl_word(ctrl_word), .mode(mode),
  .sel_idx(sel_idx), .fb_edge(fb_edge)
);

// File: tb/tb_clk_steer_dpll.sv
module tb_clk_steer_dpll;
  localparam int CLK_PERIOD = 10;
  localparam int NOM = 32768;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ref_edge = '0, ref_en = 3'b111;
  logic [5:0] ref_prio = '0;
  logic fb_edge = 1'b0;
  logic [7:0] loss_limit = 8'd4;
  logic [3:0] requal_cnt = 4'd3;
  logic [11:0] lock_win = 12'd3;
  logic [15:0] ctrl_nom = 16'(NOM), ctrl_min = 16'h0000, ctrl_max = 16'hFFFF;
  logic [15:0] ctrl_word;
  logic [1:0] mode, sel_idx;

  int checks = 0, fails = 0;
  int ph = 0, integ_m = 0, expw = NOM, w_hold = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_steer_dpll dut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .ref_en(ref_en),
    .ref_prio(ref_prio), .fb_edge(fb_edge), .loss_limit(loss_limit),
    .requal_cnt(requal_cnt), .lock_win(lock_win), .ctrl_nom(ctrl_nom),
    .ctrl_min(ctrl_min), .ctrl_max(ctrl_max), .ctrl_word(ctrl_word),
    .mode(mode), .sel_idx(sel_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [2:0] r, input logic f);
    @(negedge clk); ref_edge = r; fb_edge = f;
    @(negedge clk); ref_edge = '0; fb_edge = 1'b0;
  endtask

  task automatic period(input logic [2:0] r);
    pulse(r, 1'b1);
    repeat (6) @(negedge clk);
  endtask

  task automatic model_fb(input int with_ref);
    integ_m = integ_m + 2 * ph;
    expw = NOM + integ_m + 16 * ph;
    ph = ph + with_ref - 1;
  endtask

  task automatic extra_ref();
    pulse(3'b100, 1'b0);
    ph = ph + 1;
    @(negedge clk);
  endtask

  task automatic extra_fb();
    pulse(3'b000, 1'b1);
    model_fb(0);
    @(negedge clk);
    chk("R5 extra feedback edge word", int'(ctrl_word), expw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", int'(mode), 0);
    chk("R1 reset sel", int'(sel_idx), 3);
    chk("R1 reset word", int'(ctrl_word), NOM);

    ref_prio = 6'b00_00_00;
    period(3'b001);
    chk("R2 one edge not yet usable", int'(mode), 0);
    period(3'b001);
    chk("R2 two edges not yet usable", int'(mode), 0);
    period(3'b001);
    chk("R2 third edge qualifies", int'(mode), 1);
    chk("R3 line input selected", int'(sel_idx), 0);
    chk("R10 first lock word nominal", int'(ctrl_word), NOM);

    repeat (3) period(3'b001);
    repeat (3) period(3'b000);
    chk("R2 three silent feedback edges keep lock", int'(mode), 1);
    period(3'b000);
    chk("R2 fourth silent feedback edge loses", int'(sel_idx), 3);
    chk("R7 free-run without history", int'(mode), 0);
    chk("R7 free-run word nominal", int'(ctrl_word), NOM);

    repeat (3) period(3'b111);
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 64; p++) begin
        int eb, ep;
        ref_en = 3'(m);
        ref_prio = 6'(p);
        repeat (2) @(negedge clk);
        eb = 3; ep = 4;
        for (int i = 0; i < 3; i++) begin
          int pr;
          pr = (p >> (2 * i)) & 3;
          if (((m >> i) & 1) == 1 && pr < ep) begin eb = i; ep = pr; end
        end
        chk("R3 priority and enable sweep sel", int'(sel_idx), eb);
        chk("R3 priority and enable sweep mode", int'(mode), (eb == 3) ? 0 : 1);
        if (eb == 3) chk("R7 free-run word in sweep", int'(ctrl_word), NOM);
      end
    end

    ref_en = 3'b111;
    ref_prio = 6'b01_00_11;
    repeat (2) @(negedge clk);
    chk("R3 tributary preferred", int'(sel_idx), 1);
    repeat (3) period(3'b101);
    chk("R2 tributary still held", int'(sel_idx), 1);
    period(3'b101);
    chk("R2 tributary lost, external taken", int'(sel_idx), 2);
    chk("R10 switch word nominal without history", int'(ctrl_word), NOM);
    ph = 0; integ_m = 0;

    period(3'b101); model_fb(1);
    chk("R4 aligned edges hold zero error", int'(ctrl_word), expw);
    for (int k = -3; k <= 3; k++) begin
      int a;
      a = (k < 0) ? -k : k;
      for (int j = 0; j < a; j++) if (k > 0) extra_ref(); else extra_fb();
      period(3'b101); model_fb(1);
      chk("R5 phase step word", int'(ctrl_word), expw);
      for (int j = 0; j < a; j++) if (k > 0) extra_fb(); else extra_ref();
      period(3'b101); model_fb(1);
      chk("R4 phase restored word", int'(ctrl_word), expw);
    end
    w_hold = NOM + integ_m;

    repeat (40) period(3'b101);
    chk("R5 steady word after sweep", int'(ctrl_word), w_hold);
    chk("R3 still locked", int'(mode), 1);

    lock_win = 12'd0;
    repeat (5) period(3'b000);
    chk("R9 holdover mode", int'(mode), 2);
    chk("R9 holdover sel none", int'(sel_idx), 3);
    chk("R8 history equals converged word", int'(ctrl_word), w_hold);
    repeat (4) @(negedge clk);
    chk("R9 holdover word held", int'(ctrl_word), w_hold);

    repeat (3) period(3'b001);
    chk("R10 relock mode", int'(mode), 1);
    chk("R10 relock sel", int'(sel_idx), 0);
    chk("R10 relock word no step", int'(ctrl_word), w_hold);
    period(3'b001);
    chk("R10 preloaded integrator keeps word", int'(ctrl_word), w_hold);

    ctrl_max = 16'(w_hold - 1);
    period(3'b001);
    chk("R6 upper clamp", int'(ctrl_word), w_hold - 1);
    ctrl_max = 16'hFFFF;
    ctrl_min = 16'(w_hold + 5);
    period(3'b001);
    chk("R6 lower clamp", int'(ctrl_word), w_hold + 5);
    ctrl_min = 16'h0000;
    period(3'b001);
    chk("R6 clamp released", int'(ctrl_word), w_hold);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule